// File: doc/BRIEF.md
# Two-wire controller register interface

This block is the register front end of a two-wire serial controller. A simple peripheral bus reaches it through an address, a read/write flag, an access-size code and 16-bit data. It holds the controller's settings, collects status from the serial engine and stores one transmit word and one receive word. The serial engine, its clock generator and any real queues sit outside this block. They read the settings and the transmit word from dedicated outputs. They report events through set pulses and live status inputs, and they load received data through a strobe.

Every register has one access rule. Some are plain storage. Interrupt status clears on a write of one to any bit. Master status clears only its error bits that way, and the rest of its bits follow the engine. Several registers are read-only. The two transmit registers read back as zero: one stores only a byte, the other a full word. A single interrupt line is raised when any enabled status bit is set.

A request is accepted in the cycle in which `req_valid` is high. A write takes effect at that clock edge. The read data and the error flag for that request are registered and appear on the next cycle.

Top module: `twc_regs`

## Requirements
- R1: After reset, all stored registers are zero: configuration, interrupt status, the master error bits, and the transmit and receive holding words. `irq` is low and `tx_data` and all configuration outputs read zero.
- R2: Only size code 2'b01 (16 bits) is a valid access. Any other size returns `rsp_err`=1 and `rsp_rdata`=0 one cycle later and changes no state.
- R3: The mapped offsets are 0x00 to 0x2C in steps of 4 (clock divider 0x00, control 0x04, slave control 0x08, slave status 0x0C, slave address 0x10, master control 0x14, master status 0x18, master address 0x1C, interrupt status 0x20, interrupt mask 0x24, queue control 0x28, queue status 0x2C) and 0x80, 0x84, 0x88 and 0x8C. Any other offset, on a read or a write, gives `rsp_err`=1 and `rsp_rdata`=0 and has no effect.
- R4: Clock divider, control, slave control, slave address, master control, master address, interrupt mask and queue control store a whole written word. They read it back and drive it on their configuration outputs.
- R5: Interrupt status bit i is set by a pulse on `int_set[i]`. A write to 0x20 clears every bit written as one and leaves the bits written as zero.
- R6: Master status bits 7 (buffer read error), 6 (buffer write error), 3 (data not acknowledged), 2 (address not acknowledged) and 1 (arbitration lost) are sticky. `mst_err_set` sets them and a write of one clears them. The other bits read as `mst_live`, and writes do not change them.
- R7: Slave status (0x0C) and queue status (0x2C) read the live inputs `slv_stat_in` and `fifo_stat_in`. Writes to them, and to the receive registers, are discarded without error.
- R8: A write to 0x80 stores {8'h00, wdata[7:0]} in the transmit word. A write to 0x84 stores the full wdata. Both drive `tx_data` from the next cycle.
- R9: Reads of 0x80 and 0x84 return zero. Reads of 0x88 and 0x8C return the receive word, which `rx_load` loads from `rx_data`.
- R10: A status set pulse wins over a write-one clear of the same bit in the same cycle.
- R11: `irq` is high exactly when some bit is set in both interrupt status and interrupt mask. It follows a change of either one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code, 2'b01 = 16 bits |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Read data, one cycle after request |
| rsp_err | output | 1 | Error response, one cycle after request |
| int_set | input | 16 | Interrupt status set pulses |
| mst_err_set | input | 16 | Master error set pulses (bits 7,6,3,2,1 used) |
| mst_live | input | 16 | Live master status (non-error bits) |
| slv_stat_in | input | 16 | Live slave status |
| fifo_stat_in | input | 16 | Live queue status |
| rx_load | input | 1 | Load strobe for receive word |
| rx_data | input | 16 | Received word |
| tx_data | output | 16 | Transmit holding word |
| cfg_clkdiv | output | 16 | Clock divider setting |
| cfg_ctrl | output | 16 | Control setting |
| cfg_slv_ctl | output | 16 | Slave control setting |
| cfg_slv_addr | output | 16 | Slave address setting |
| cfg_mst_ctl | output | 16 | Master control setting |
| cfg_mst_addr | output | 16 | Master address setting |
| cfg_fifo_ctl | output | 16 | Queue control setting |
| irq | output | 1 | Interrupt request |

## Verification
A request driven during cycle n is registered at the edge that ends that cycle. Its `rsp_rdata` and `rsp_err` are valid during cycle n+1. A write's effect on `tx_data`, `irq` and the configuration outputs also appears in cycle n+1, as does the effect of a set pulse or an `rx_load` strobe. The bench drives each request at a falling edge and withdraws it at the next falling edge. It samples every output at that second falling edge, half a period after the one edge that produces all of these results. Expected values come from a small register model in the bench, which applies clears before sets. The model is consulted before it is updated, so a read is compared against the state that existed before the request.

// File: rtl/twc_regs_pkg.sv
package twc_regs_pkg;

    localparam int DW   = 16;
    localparam int NCFG = 8;

    localparam logic [1:0]    SZ_HALF      = 2'b01;
    // sticky error bits of master status: 7,6,3,2,1
    localparam logic [DW-1:0] MST_ERR_MASK = 16'h00CE;
    localparam logic [DW-1:0] ALL_ONES     = '1;

    typedef enum logic [4:0] {
        RI_CLKDIV   = 5'd0,
        RI_CTRL     = 5'd1,
        RI_SLVCTL   = 5'd2,
        RI_SLVSTAT  = 5'd3,
        RI_SLVADDR  = 5'd4,
        RI_MSTCTL   = 5'd5,
        RI_MSTSTAT  = 5'd6,
        RI_MSTADDR  = 5'd7,
        RI_INTSTAT  = 5'd8,
        RI_INTMASK  = 5'd9,
        RI_FIFOCTL  = 5'd10,
        RI_FIFOSTAT = 5'd11,
        RI_TX8      = 5'd12,
        RI_TX16     = 5'd13,
        RI_RX8      = 5'd14,
        RI_RX16     = 5'd15,
        RI_NONE     = 5'd31
    } reg_id_e;

    // storage slots of the plain read/write registers
    localparam logic [2:0] SLOT_CLKDIV  = 3'd0;
    localparam logic [2:0] SLOT_CTRL    = 3'd1;
    localparam logic [2:0] SLOT_SLVCTL  = 3'd2;
    localparam logic [2:0] SLOT_SLVADDR = 3'd3;
    localparam logic [2:0] SLOT_MSTCTL  = 3'd4;
    localparam logic [2:0] SLOT_MSTADDR = 3'd5;
    localparam logic [2:0] SLOT_INTMASK = 3'd6;
    localparam logic [2:0] SLOT_FIFOCTL = 3'd7;

    typedef struct packed {
        logic [NCFG-1:0][DW-1:0] cfg;
        logic [DW-1:0]           tx;
        logic [DW-1:0]           rx;
        logic [DW-1:0]           rdata;
        logic                    err;
    } core_t;

    // {hit, slot}: where a plain register lives in storage
    function automatic logic [3:0] cfg_slot(reg_id_e id);
        case (id)
            RI_CLKDIV:  return {1'b1, SLOT_CLKDIV};
            RI_CTRL:    return {1'b1, SLOT_CTRL};
            RI_SLVCTL:  return {1'b1, SLOT_SLVCTL};
            RI_SLVADDR: return {1'b1, SLOT_SLVADDR};
            RI_MSTCTL:  return {1'b1, SLOT_MSTCTL};
            RI_MSTADDR: return {1'b1, SLOT_MSTADDR};
            RI_INTMASK: return {1'b1, SLOT_INTMASK};
            RI_FIFOCTL: return {1'b1, SLOT_FIFOCTL};
            default:    return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/twc_decode.sv
module twc_decode
    import twc_regs_pkg::*;
#(
    parameter int AW        = 8,
    parameter int NUM_CTRL  = 12,
    parameter int NUM_DATA  = 4,
    parameter int DATA_BASE = 128
) (
    input  logic [AW-1:0] addr,
    output reg_id_e       id
);

    localparam int WORD_W    = AW - 2;
    localparam int DATA_WORD = DATA_BASE / 4;

    logic [WORD_W-1:0] word;
    int                widx;

    always_comb begin
        word = addr[AW-1:2];
        widx = int'(word);
        id   = RI_NONE;
        if (addr[1:0] == 2'b00) begin
            if (widx < NUM_CTRL) begin
                id = reg_id_e'(5'(widx));
            end else if (widx >= DATA_WORD && widx < DATA_WORD + NUM_DATA) begin
                id = reg_id_e'(5'(widx - DATA_WORD + NUM_CTRL));
            end
        end
    end

endmodule

// File: rtl/twc_w1c.sv
module twc_w1c #(
    parameter int             W        = 16,
    parameter logic [W-1:0]   CLR_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_en_i,
    input  logic [W-1:0] clr_bits_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stat_d, stat_q;
    logic [W-1:0] clr_eff;

    always_comb begin
        clr_eff = clr_en_i ? (clr_bits_i & CLR_MASK) : '0;
        // a set in the same cycle wins over the clear
        stat_d  = (stat_q & ~clr_eff) | (set_i & CLR_MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign q_o = stat_q;

endmodule

// File: rtl/twc_regs.sv
module twc_regs
    import twc_regs_pkg::*;
#(
    parameter int AW        = 8,
    parameter int DATA_BASE = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [1:0]    req_size,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_wdata,
    output logic [15:0]   rsp_rdata,
    output logic          rsp_err,
    input  logic [15:0]   int_set,
    input  logic [15:0]   mst_err_set,
    input  logic [15:0]   mst_live,
    input  logic [15:0]   slv_stat_in,
    input  logic [15:0]   fifo_stat_in,
    input  logic          rx_load,
    input  logic [15:0]   rx_data,
    output logic [15:0]   tx_data,
    output logic [15:0]   cfg_clkdiv,
    output logic [15:0]   cfg_ctrl,
    output logic [15:0]   cfg_slv_ctl,
    output logic [15:0]   cfg_slv_addr,
    output logic [15:0]   cfg_mst_ctl,
    output logic [15:0]   cfg_mst_addr,
    output logic [15:0]   cfg_fifo_ctl,
    output logic          irq
);

    reg_id_e       acc_id;
    core_t         st_d, st_q;
    logic          size_ok, hit, bad, wr_ok;
    logic [3:0]    slot_info;
    logic [DW-1:0] rd_val;
    logic          int_clr, mst_clr;
    logic [DW-1:0] int_q, mst_q, int_mask_q, rx_q;

    twc_decode #(
        .AW        (AW),
        .NUM_CTRL  (12),
        .NUM_DATA  (4),
        .DATA_BASE (DATA_BASE)
    ) u_dec (
        .addr (req_addr),
        .id   (acc_id)
    );

    twc_w1c #(
        .W        (DW),
        .CLR_MASK (ALL_ONES)
    ) u_int (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (int_set),
        .clr_en_i   (int_clr),
        .clr_bits_i (req_wdata),
        .q_o        (int_q)
    );

    twc_w1c #(
        .W        (DW),
        .CLR_MASK (MST_ERR_MASK)
    ) u_mst (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (mst_err_set),
        .clr_en_i   (mst_clr),
        .clr_bits_i (req_wdata),
        .q_o        (mst_q)
    );

    always_comb begin
        st_d      = st_q;
        size_ok   = (req_size == SZ_HALF);
        hit       = (acc_id != RI_NONE);
        bad       = req_valid && !(size_ok && hit);
        wr_ok     = req_valid && req_write && size_ok && hit;
        slot_info = cfg_slot(acc_id);
        int_clr   = wr_ok && (acc_id == RI_INTSTAT);
        mst_clr   = wr_ok && (acc_id == RI_MSTSTAT);

        // read mux over current state
        if (slot_info[3]) begin
            rd_val = st_q.cfg[slot_info[2:0]];
        end else begin
            case (acc_id)
                RI_SLVSTAT:  rd_val = slv_stat_in;
                RI_MSTSTAT:  rd_val = (mst_live & ~MST_ERR_MASK) | mst_q;
                RI_INTSTAT:  rd_val = int_q;
                RI_FIFOSTAT: rd_val = fifo_stat_in;
                RI_RX8,
                RI_RX16:     rd_val = st_q.rx;
                default:     rd_val = '0;
            endcase
        end

        // writes
        if (wr_ok) begin
            if (slot_info[3]) begin
                st_d.cfg[slot_info[2:0]] = req_wdata;
            end
            case (acc_id)
                RI_TX8:  st_d.tx = {8'h00, req_wdata[7:0]};
                RI_TX16: st_d.tx = req_wdata;
                default: ;
            endcase
        end

        if (rx_load) begin
            st_d.rx = rx_data;
        end

        st_d.rdata = (req_valid && !req_write && !bad) ? rd_val : '0;
        st_d.err   = bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign int_mask_q   = st_q.cfg[SLOT_INTMASK];
    assign rx_q         = st_q.rx;

    assign rsp_rdata    = st_q.rdata;
    assign rsp_err      = st_q.err;
    assign tx_data      = st_q.tx;
    assign cfg_clkdiv   = st_q.cfg[SLOT_CLKDIV];
    assign cfg_ctrl     = st_q.cfg[SLOT_CTRL];
    assign cfg_slv_ctl  = st_q.cfg[SLOT_SLVCTL];
    assign cfg_slv_addr = st_q.cfg[SLOT_SLVADDR];
    assign cfg_mst_ctl  = st_q.cfg[SLOT_MSTCTL];
    assign cfg_mst_addr = st_q.cfg[SLOT_MSTADDR];
    assign cfg_fifo_ctl = st_q.cfg[SLOT_FIFOCTL];
    assign irq          = |(int_q & int_mask_q);

endmodule

// File: rtl/twc_regs_chk.sv
module twc_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [1:0]  req_size,
    input logic [7:0]  req_addr,
    input logic [15:0] req_wdata,
    input logic [15:0] rsp_rdata,
    input logic        rsp_err,
    input logic [15:0] int_set,
    input logic [15:0] mst_err_set,
    input logic        rx_load,
    input logic [15:0] rx_data,
    input logic        irq,
    input logic [15:0] int_q,
    input logic [15:0] mst_q,
    input logic [15:0] int_mask_q,
    input logic [15:0] rx_q
);

    a_r2_size_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size != 2'b01) |=> (rsp_err && rsp_rdata == 16'h0));

    a_r3_unaligned_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[1:0] != 2'b00) |=> rsp_err);

    a_r9_tx_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size == 2'b01 && req_addr[7:3] == 5'b10000
         && req_addr[1:0] == 2'b00) |=> (rsp_rdata == 16'h0 && !rsp_err));

    a_r11_irq_on_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((int_set & int_mask_q) != 16'h0 && !(req_valid && req_write)) |=> irq);

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (int_set != 16'h0) |=> ((int_q & $past(int_set)) == $past(int_set)));

    a_r6_err_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_size == 2'b01 && req_addr == 8'h18
         && req_wdata == 16'hFFFF && mst_err_set == 16'h0) |=> (mst_q == 16'h0));

    a_r9_rx_load: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load |=> (rx_q == $past(rx_data)));

endmodule

bind twc_regs twc_regs_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_size    (req_size),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .rsp_rdata   (rsp_rdata),
    .rsp_err     (rsp_err),
    .int_set     (int_set),
    .mst_err_set (mst_err_set),
    .rx_load     (rx_load),
    .rx_data     (rx_data),
    .irq         (irq),
    .int_q       (int_q),
    .mst_q       (mst_q),
    .int_mask_q  (int_mask_q),
    .rx_q        (rx_q)
);

// File: tb/twc_regs_test.sv
module twc_regs_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] ERRM = 16'h00CE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = 2'b01;
    logic [7:0]  req_addr = 8'h0;
    logic [15:0] req_wdata = 16'h0;
    logic [15:0] rsp_rdata;
    logic        rsp_err;
    logic [15:0] int_set = 16'h0, mst_err_set = 16'h0;
    logic [15:0] mst_live = 16'h0, slv_stat_in = 16'h0, fifo_stat_in = 16'h0;
    logic        rx_load = 1'b0;
    logic [15:0] rx_data = 16'h0;
    logic [15:0] tx_data, cfg_clkdiv, cfg_ctrl, cfg_slv_ctl, cfg_slv_addr;
    logic [15:0] cfg_mst_ctl, cfg_mst_addr, cfg_fifo_ctl;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;

    // bench model
    logic [15:0] m_cfg [8];
    logic [15:0] m_tx, m_rx, m_int, m_mst;

    always #(CLK_PERIOD/2) clk = ~clk;

    twc_regs uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .int_set(int_set), .mst_err_set(mst_err_set), .mst_live(mst_live),
        .slv_stat_in(slv_stat_in), .fifo_stat_in(fifo_stat_in),
        .rx_load(rx_load), .rx_data(rx_data), .tx_data(tx_data),
        .cfg_clkdiv(cfg_clkdiv), .cfg_ctrl(cfg_ctrl), .cfg_slv_ctl(cfg_slv_ctl),
        .cfg_slv_addr(cfg_slv_addr), .cfg_mst_ctl(cfg_mst_ctl),
        .cfg_mst_addr(cfg_mst_addr), .cfg_fifo_ctl(cfg_fifo_ctl), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic bit mapped(input logic [7:0] a);
        return (a[1:0] == 2'b00) && ((a < 8'h30) || (a >= 8'h80 && a < 8'h90));
    endfunction

    function automatic int idx_of(input logic [7:0] a);
        return (a < 8'h30) ? int'(a >> 2) : 12 + int'((a - 8'h80) >> 2);
    endfunction

    // plain-register slot, -1 if not plain storage
    function automatic int slot_of(input int i);
        case (i)
            0: return 0;  1: return 1;  2: return 2;  4: return 3;
            5: return 4;  7: return 5;  9: return 6;  10: return 7;
            default: return -1;
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] sz, input logic [7:0] a);
        int i;
        if (sz != 2'b01) return "R2";
        if (!mapped(a))  return "R3";
        i = idx_of(a);
        if (slot_of(i) >= 0) return "R4";
        case (i)
            8:       return "R5";
            6:       return "R6";
            3, 11:   return "R7";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [15:0] model_read(input int i);
        if (slot_of(i) >= 0) return m_cfg[slot_of(i)];
        case (i)
            3:      return slv_stat_in;
            6:      return (mst_live & ~ERRM) | m_mst;
            8:      return m_int;
            11:     return fifo_stat_in;
            14, 15: return m_rx;
            default: return 16'h0;
        endcase
    endfunction

    task automatic acc(input logic v, input logic w, input logic [1:0] sz,
                       input logic [7:0] a, input logic [15:0] d,
                       input logic [15:0] iset, input logic [15:0] mset);
        logic        e_err;
        logic [15:0] e_rd, clr_i, clr_m;
        int          i;
        @(negedge clk);
        req_valid = v; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
        int_set = iset; mst_err_set = mset;
        e_err = v && !(sz == 2'b01 && mapped(a));
        e_rd  = 16'h0;
        clr_i = 16'h0; clr_m = 16'h0;
        if (v && !e_err) begin
            i = idx_of(a);
            if (!w) e_rd = model_read(i);
            else begin
                if (slot_of(i) >= 0) m_cfg[slot_of(i)] = d;
                if (i == 8)  clr_i = d;
                if (i == 6)  clr_m = d & ERRM;
                if (i == 12) m_tx = {8'h00, d[7:0]};
                if (i == 13) m_tx = d;
            end
        end
        m_int = (m_int & ~clr_i) | iset;
        m_mst = (m_mst & ~clr_m) | (mset & ERRM);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; int_set = 16'h0; mst_err_set = 16'h0;
        if (v) begin
            chk(tag_of(sz, a), {15'h0, rsp_err}, {15'h0, e_err});
            chk(tag_of(sz, a), rsp_rdata, e_rd);
        end
        if ((iset & clr_i) != 16'h0 || (mset & clr_m) != 16'h0) begin
            chk("R10 int", uut.int_q, m_int);
        end
        chk("R8 tx_data", tx_data, m_tx);
        chk("R11 irq", {15'h0, irq}, {15'h0, |(m_int & m_cfg[6])});
    endtask

    task automatic rd(input logic [7:0] a);
        acc(1'b1, 1'b0, 2'b01, a, 16'h0, 16'h0, 16'h0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        acc(1'b1, 1'b1, 2'b01, a, d, 16'h0, 16'h0);
    endtask

    task automatic read_all_mapped();
        for (int a = 0; a < 256; a += 4) begin
            if (mapped(8'(a))) rd(8'(a));
        end
    endtask

    task automatic chk_cfg_outs(input string tag);
        chk(tag, cfg_clkdiv,   m_cfg[0]);
        chk(tag, cfg_ctrl,     m_cfg[1]);
        chk(tag, cfg_slv_ctl,  m_cfg[2]);
        chk(tag, cfg_slv_addr, m_cfg[3]);
        chk(tag, cfg_mst_ctl,  m_cfg[4]);
        chk(tag, cfg_mst_addr, m_cfg[5]);
        chk(tag, cfg_fifo_ctl, m_cfg[7]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) m_cfg[k] = 16'h0;
        m_tx = 16'h0; m_rx = 16'h0; m_int = 16'h0; m_mst = 16'h0;
        slv_stat_in = 16'h1234; fifo_stat_in = 16'h0055; mst_live = 16'hA5F1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1 irq", {15'h0, irq}, 16'h0);
        chk("R1 tx_data", tx_data, 16'h0);
        chk_cfg_outs("R1 cfg");
        chk("R1 rsp_err", {15'h0, rsp_err}, 16'h0);

        // R2/R3: every size over every offset, reads
        for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < 256; a++) begin
                acc(1'b1, 1'b0, 2'(s), 8'(a), 16'h0, 16'h0, 16'h0);
            end
        end

        // R4: write a distinct word to every plain register
        for (int a = 0; a < 16'h30; a += 4) begin
            if (slot_of(idx_of(8'(a))) >= 0) wr(8'(a), 16'h5A00 ^ 16'(a * 16'h0123));
        end
        wr(8'h24, 16'h0000);
        chk_cfg_outs("R4 cfg");
        read_all_mapped();

        // R2: wrong-size writes everywhere have no effect
        for (int s = 0; s < 4; s++) begin
            if (s == 1) continue;
            for (int a = 0; a < 256; a += 4) begin
                acc(1'b1, 1'b1, 2'(s), 8'(a), 16'hFFFF, 16'h0, 16'h0);
            end
        end
        chk_cfg_outs("R2 cfg");
        // R3: unmapped writes have no effect
        wr(8'h02, 16'hFFFF); wr(8'h30, 16'hFFFF); wr(8'h7C, 16'hFFFF);
        wr(8'h90, 16'hFFFF); wr(8'h86, 16'hFFFF);
        chk_cfg_outs("R3 cfg");
        read_all_mapped();

        // R5/R11: interrupt status and mask
        acc(1'b0, 1'b0, 2'b01, 8'h0, 16'h0, 16'hF0F0, 16'h0);
        rd(8'h20);
        wr(8'h24, 16'h0F00);
        acc(1'b0, 1'b0, 2'b01, 8'h0, 16'h0, 16'h0100, 16'h0);
        wr(8'h20, 16'h0100);
        wr(8'h20, 16'h00F0);
        rd(8'h20);
        wr(8'h24, 16'hFFFF);
        // R10: set wins over same-cycle clear
        acc(1'b1, 1'b1, 2'b01, 8'h20, 16'hFFFF, 16'h0003, 16'h0);
        rd(8'h20);
        wr(8'h20, 16'hFFFF);

        // R6: master status
        acc(1'b0, 1'b0, 2'b01, 8'h0, 16'h0, 16'h0, 16'hFFFF);
        rd(8'h18);
        wr(8'h18, 16'h00C0);
        rd(8'h18);
        wr(8'h18, 16'hFF31);
        rd(8'h18);
        mst_live = 16'h5A0E;
        rd(8'h18);
        acc(1'b1, 1'b1, 2'b01, 8'h18, 16'hFFFF, 16'h0, 16'h0002);
        rd(8'h18);
        wr(8'h18, 16'hFFFF);
        rd(8'h18);

        // R9: receive word
        @(negedge clk); rx_load = 1'b1; rx_data = 16'h9C3E;
        @(negedge clk); rx_load = 1'b0; m_rx = 16'h9C3E;
        rd(8'h88); rd(8'h8C);
        // R7: read-only writes are discarded
        wr(8'h88, 16'h1111); wr(8'h8C, 16'h2222);
        wr(8'h0C, 16'hFFFF); wr(8'h2C, 16'hFFFF);
        rd(8'h88); rd(8'h8C); rd(8'h0C); rd(8'h2C);
        slv_stat_in = 16'hC001; fifo_stat_in = 16'h0E00;
        rd(8'h0C); rd(8'h2C);

        // R8: transmit word paths
        wr(8'h80, 16'hBEEF);
        chk("R8 tx8", tx_data, 16'h00EF);
        wr(8'h84, 16'hBEEF);
        chk("R8 tx16", tx_data, 16'hBEEF);
        rd(8'h80); rd(8'h84);
        wr(8'h80, 16'h12A5);
        chk("R8 tx8 upper zero", tx_data, 16'h00A5);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule